// File: doc/BRIEF.md
# Multi-Loop E1 Timeslot Reassembler

This block rebuilds one 2048 kbps E1 bit stream from the payload carried by up to three HDSL loops. Each loop delivers one bit at a time on a bit strobe, together with a flag that marks overhead positions. Each loop has its own small FIFO. Overhead bits are kept out of it, so only payload bits reach that FIFO. On the E1 side, a bit-position counter walks a 256-bit frame of 32 timeslots with 8 bits each. For each timeslot, a map says which loop FIFO supplies the bits or whether the timeslot is idle. The block drives an E1 data bit and a frame pulse.

The map is written through a small configuration port into a shadow copy. A load strobe arms a transfer, and the shadow copy becomes active only at the next frame boundary. Four override bits can replace the output with all ones (AIS). Three of them act per loop. The fourth acts on the whole stream, and while it is set the stream is paced by a nominal-rate strobe rather than the recovered E1 strobe. When a FIFO reads while empty or writes while full, a sticky error bit is set and AIS is forced until the frame ends. A one-cycle gapped reference tick is produced for each payload bit accepted on loop 0, as a timing reference for an E1 clock generator.

All inputs are sampled in one clock domain; loop and E1 bit timing arrive as single-cycle strobes.

Top module: `e1_reassembler`

## Requirements
- R1: A loop bit presented with its overhead flag high is not stored. Only bits with the flag low enter that loop's FIFO, and each loop has its own FIFO.
- R2: For the bit at frame position p, the active map entry of timeslot p/8 selects the source. Codes 0, 1 and 2 take the next bit of that loop's FIFO. Code 3 is idle and outputs a one without reading any FIFO.
- R3: Map writes go to a shadow copy and do not change the output. A load strobe raises `load_pending`. At the last bit of the current frame, the shadow copy becomes active and `load_pending` clears by itself, so the new map governs from bit 0 of the next frame.
- R4: A frame is 256 advance strobes. `e1_fp` is high for exactly one cycle, together with the data bit of position 0. After reset the first advance is position 0.
- R5: `e1_data` and `e1_fp` change only on the clock edge that samples an advance strobe, and `e1_fp` is otherwise low. After reset, `e1_data`, `e1_fp`, `gap_tick`, `fifo_err` and `load_pending` are all 0 and every map entry is idle (code 3).
- R6: When `ais_ctl[l]` is set for l in 0..2, timeslots mapped to loop l output ones. That FIFO is still read, so its alignment is kept.
- R7: When `ais_ctl[3]` is set, every output bit is one and the frame position advances on `nom_en` instead of `e1_en`. The frame pulse still marks position 0, and no FIFO is read.
- R8: A read of an empty FIFO outputs a one and sets the sticky bit `fifo_err[l]`. Ones are forced for the rest of that frame, and normal output resumes at the next frame.
- R9: A payload write to a full FIFO with no read in the same cycle drops the bit and sets the sticky bit `fifo_err[l]`. Ones are forced until the end of the frame.
- R10: `gap_tick` is high for one cycle, one cycle after loop 0 presents a bit with the overhead flag low. It stays low after loop 0 overhead bits and after bits on other loops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| loop_bit_en | input | NUM_LOOPS | Per-loop bit strobe |
| loop_oh | input | NUM_LOOPS | Per-loop overhead flag for the strobed bit |
| loop_data | input | NUM_LOOPS | Per-loop received bit |
| e1_en | input | 1 | E1 bit advance strobe |
| nom_en | input | 1 | Nominal-rate advance strobe used under full AIS |
| ais_ctl | input | NUM_LOOPS+1 | Per-loop AIS bits, top bit is full-stream AIS |
| cfg_we | input | 1 | Shadow map write strobe |
| cfg_ts | input | $clog2(TS_NUM) | Timeslot written |
| cfg_code | input | 2 | Source code: loop 0..2, 3 idle |
| cfg_load | input | 1 | Arm shadow-to-active transfer |
| e1_data | output | 1 | Reassembled E1 bit |
| e1_fp | output | 1 | Frame pulse with bit 0 of timeslot 0 |
| gap_tick | output | 1 | Gapped payload reference tick from loop 0 |
| fifo_err | output | NUM_LOOPS | Sticky FIFO under/overflow flags |
| load_pending | output | 1 | Map transfer armed, not yet done |

## Verification
The embedded properties watch, on every cycle, several local rules. Overhead strobes leave a FIFO's fill level untouched. The active map and the pending flag change only at a frame's last bit. Frame pulses are single cycles. Output holds between advance strobes. Full-stream AIS yields ones, and error flags never drop. Only the bench's scenarios show that bits actually arrive in map order across loops. They also show that a mid-frame reload waits for the boundary, and that a muted loop keeps its FIFO aligned. Finally, the scenarios show that an underflow or overflow blanks exactly the rest of one frame.

// File: rtl/e1r_pkg.sv
package e1r_pkg;
    localparam int CODE_W = 2;
    typedef logic [CODE_W-1:0] loop_code_t;
    localparam loop_code_t CODE_IDLE = 2'd3;

    typedef struct packed {
        logic data;
        logic fp;
    } e1_bit_t;

    function automatic logic code_is_loop(input loop_code_t c, input int n);
        return int'(c) < n;
    endfunction
endpackage

// File: rtl/e1r_loop_fifo.sv
module e1r_loop_fifo #(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic oh,
    input  logic din,
    input  logic pop,
    output logic dout,
    output logic empty,
    output logic ovf_evt
);
    localparam int AW = $clog2(DEPTH);

    logic [DEPTH-1:0] mem;
    logic [AW-1:0]    wp, rp;
    logic [AW:0]      cnt;
    logic             push, do_pop, full, wr;

    assign push    = bit_en & ~oh;
    assign empty   = (cnt == '0);
    assign full    = (cnt == (AW+1)'(DEPTH));
    assign do_pop  = pop & ~empty;
    assign wr      = push & (~full | do_pop);
    assign ovf_evt = push & full & ~do_pop;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (wr) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr)     wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_pop) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            cnt <= cnt + (AW+1)'(wr) - (AW+1)'(do_pop);
        end
    end

    // R1
    oh_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_en && oh && !pop) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/e1r_ts_map.sv
module e1r_ts_map
    import e1r_pkg::*;
#(
    parameter int TS_NUM = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_we,
    input  logic [$clog2(TS_NUM)-1:0] cfg_ts,
    input  loop_code_t                cfg_code,
    input  logic                      cfg_load,
    input  logic                      wrap,
    input  logic [$clog2(TS_NUM)-1:0] rd_ts,
    output loop_code_t                rd_code,
    output logic                      pending
);
    logic [TS_NUM-1:0][CODE_W-1:0] shadow, active;

    assign rd_code = active[rd_ts];

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow  <= '1;
            active  <= '1;
            pending <= 1'b0;
        end else begin
            if (cfg_we) shadow[cfg_ts] <= cfg_code;
            if (wrap && pending) active <= shadow;
            pending <= (pending & ~wrap) | cfg_load;
        end
    end

    // R3
    act_swap_chk: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(active));
    // R3
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pending) |-> $past(wrap));
endmodule

// File: rtl/e1r_seq.sv
module e1r_seq
    import e1r_pkg::*;
#(
    parameter int NUM_LOOPS = 3,
    parameter int TS_NUM    = 32,
    parameter int TS_BITS   = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      e1_en,
    input  logic                      nom_en,
    input  logic [NUM_LOOPS:0]        ais_ctl,
    input  loop_code_t                code,
    input  logic [NUM_LOOPS-1:0]      fifo_dout,
    input  logic [NUM_LOOPS-1:0]      fifo_empty,
    input  logic [NUM_LOOPS-1:0]      ovf_evt,
    output logic [$clog2(TS_NUM)-1:0] cur_ts,
    output logic                      wrap,
    output logic [NUM_LOOPS-1:0]      pop,
    output logic                      e1_data,
    output logic                      e1_fp,
    output logic [NUM_LOOPS-1:0]      err
);
    localparam int FRAME = TS_NUM * TS_BITS;
    localparam int PW    = $clog2(FRAME);
    localparam int BW    = $clog2(TS_BITS);

    logic [PW-1:0]        pos;
    logic                 hold, tick, ais_all, is_loop, force_one, bit_v;
    logic [NUM_LOOPS-1:0] sel, udf;
    e1_bit_t              out_q;

    assign ais_all = ais_ctl[NUM_LOOPS];
    assign tick    = ais_all ? nom_en : e1_en;
    assign cur_ts  = pos[PW-1:BW];
    assign is_loop = code_is_loop(code, NUM_LOOPS);
    assign wrap    = tick & (pos == PW'(FRAME-1));

    always_comb begin
        for (int l = 0; l < NUM_LOOPS; l++) begin
            sel[l] = (int'(code) == l);
            pop[l] = tick & ~ais_all & sel[l];
        end
    end

    assign udf       = pop & fifo_empty;
    assign force_one = ais_all | hold | ~is_loop | (|udf)
                     | (|(sel & ais_ctl[NUM_LOOPS-1:0]));
    assign bit_v     = force_one | (|(sel & fifo_dout));

    always_ff @(posedge clk) begin
        if (rst) begin
            pos   <= '0;
            out_q <= '0;
            hold  <= 1'b0;
            err   <= '0;
        end else begin
            out_q.fp <= tick & (pos == '0);
            if (tick) begin
                out_q.data <= bit_v;
                pos        <= pos + 1'b1;
            end
            hold <= (hold & ~wrap) | (|udf) | (|ovf_evt);
            err  <= err | udf | ovf_evt;
        end
    end

    assign e1_data = out_q.data;
    assign e1_fp   = out_q.fp;

    // R7
    ais_all_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && ais_all) |=> e1_data);
    // R4
    fp_single_chk: assert property (@(posedge clk) disable iff (rst)
        e1_fp |=> !e1_fp);
    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(e1_data));
    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((err & $past(err)) == $past(err)));
endmodule

// File: rtl/e1_reassembler.sv
module e1_reassembler
    import e1r_pkg::*;
#(
    parameter int NUM_LOOPS  = 3,
    parameter int FIFO_DEPTH = 16,
    parameter int TS_NUM     = 32,
    parameter int TS_BITS    = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_LOOPS-1:0]      loop_bit_en,
    input  logic [NUM_LOOPS-1:0]      loop_oh,
    input  logic [NUM_LOOPS-1:0]      loop_data,
    input  logic                      e1_en,
    input  logic                      nom_en,
    input  logic [NUM_LOOPS:0]        ais_ctl,
    input  logic                      cfg_we,
    input  logic [$clog2(TS_NUM)-1:0] cfg_ts,
    input  logic [1:0]                cfg_code,
    input  logic                      cfg_load,
    output logic                      e1_data,
    output logic                      e1_fp,
    output logic                      gap_tick,
    output logic [NUM_LOOPS-1:0]      fifo_err,
    output logic                      load_pending
);
    localparam int TW = $clog2(TS_NUM);

    logic [NUM_LOOPS-1:0] f_dout, f_empty, f_ovf, f_pop;
    logic [TW-1:0]        cur_ts;
    logic                 wrap;
    loop_code_t           code;

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
        e1r_loop_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
            .clk    (clk),
            .rst    (rst),
            .bit_en (loop_bit_en[g]),
            .oh     (loop_oh[g]),
            .din    (loop_data[g]),
            .pop    (f_pop[g]),
            .dout   (f_dout[g]),
            .empty  (f_empty[g]),
            .ovf_evt(f_ovf[g])
        );
    end

    e1r_ts_map #(.TS_NUM(TS_NUM)) u_map (
        .clk     (clk),
        .rst     (rst),
        .cfg_we  (cfg_we),
        .cfg_ts  (cfg_ts),
        .cfg_code(loop_code_t'(cfg_code)),
        .cfg_load(cfg_load),
        .wrap    (wrap),
        .rd_ts   (cur_ts),
        .rd_code (code),
        .pending (load_pending)
    );

    e1r_seq #(.NUM_LOOPS(NUM_LOOPS), .TS_NUM(TS_NUM), .TS_BITS(TS_BITS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .e1_en     (e1_en),
        .nom_en    (nom_en),
        .ais_ctl   (ais_ctl),
        .code      (code),
        .fifo_dout (f_dout),
        .fifo_empty(f_empty),
        .ovf_evt   (f_ovf),
        .cur_ts    (cur_ts),
        .wrap      (wrap),
        .pop       (f_pop),
        .e1_data   (e1_data),
        .e1_fp     (e1_fp),
        .err       (fifo_err)
    );

    always_ff @(posedge clk) begin
        if (rst) gap_tick <= 1'b0;
        else     gap_tick <= loop_bit_en[0] & ~loop_oh[0];
    end

    // R10
    gap_src_chk: assert property (@(posedge clk) disable iff (rst)
        gap_tick |-> $past(loop_bit_en[0] && !loop_oh[0]));
endmodule

// File: tb/e1_reassembler_bench.sv
module e1_reassembler_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst;
    logic [2:0] loop_bit_en, loop_oh, loop_data;
    logic       e1_en, nom_en, cfg_we, cfg_load;
    logic [3:0] ais_ctl;
    logic [4:0] cfg_ts;
    logic [1:0] cfg_code;
    logic       e1_data, e1_fp, gap_tick, load_pending;
    logic [2:0] fifo_err;

    e1_reassembler u_e1_reassembler (
        .clk(clk), .rst(rst), .loop_bit_en(loop_bit_en), .loop_oh(loop_oh),
        .loop_data(loop_data), .e1_en(e1_en), .nom_en(nom_en), .ais_ctl(ais_ctl),
        .cfg_we(cfg_we), .cfg_ts(cfg_ts), .cfg_code(cfg_code), .cfg_load(cfg_load),
        .e1_data(e1_data), .e1_fp(e1_fp), .gap_tick(gap_tick),
        .fifo_err(fifo_err), .load_pending(load_pending)
    );

    int nchk = 0, nfail = 0;
    bit finished = 0;
    logic [1:0] exp_q[$];
    string      req_q[$];

    int bmap_act[32], bmap_sh[32];
    bit pend = 0, bhold = 0;
    string hold_req = "R8";
    int bpos = 0, frame = 0;
    logic [3:0] bais = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: compares each produced E1 bit against the scoreboard
    logic tick_seen;
    always @(posedge clk) tick_seen <= e1_en | nom_en;
    always @(negedge clk) begin
        if (tick_seen && !rst) begin
            if (exp_q.size() == 0) check(0, "R5", "unexpected bit", 1, 0);
            else begin
                logic [1:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(e1_data == e[1], r, "e1_data", e1_data, e[1]);
                check(e1_fp == e[0], "R4", "e1_fp", e1_fp, e[0]);
            end
        end
    end

    task automatic push_bit(input int l, input bit d, input bit oh);
        loop_bit_en[l] = 1'b1; loop_oh[l] = oh; loop_data[l] = d;
        @(negedge clk);
        loop_bit_en = '0; loop_oh = '0;
        check(gap_tick == (l == 0 && !oh), "R10", "gap_tick", gap_tick, (l == 0 && !oh));
    endtask

    task automatic step(input bit skip);
        int ts = bpos / 8;
        int c = bmap_act[ts];
        bit d = ((bpos * 5 + frame * 3) % 7) < 3;
        bit e = d;
        bit had_pend = pend;
        string r = "R2";
        if (!bais[3] && c < 3) begin
            if (bpos % 6 == 0) begin push_bit(c, !d, 1'b1); r = "R1"; end
            if (!skip) push_bit(c, d, 1'b0);
        end
        if (c == 3) e = 1;
        if (c < 3 && bais[c]) begin e = 1; r = "R6"; end
        if (bhold) begin e = 1; r = hold_req; end
        if (skip && c < 3) begin e = 1; r = "R8"; end
        if (bais[3]) begin e = 1; r = "R7"; end
        exp_q.push_back({e, bpos == 0});
        req_q.push_back(r);
        if (bais[3]) nom_en = 1'b1; else e1_en = 1'b1;
        @(negedge clk);
        nom_en = 1'b0; e1_en = 1'b0;
        if (skip && c < 3 && !bais[3]) begin bhold = 1; hold_req = "R8"; end
        if (bpos == 255) begin
            bhold = 0;
            if (had_pend) begin
                bmap_act = bmap_sh; pend = 0;
                check(load_pending == 1'b0, "R3", "load_pending after boundary", load_pending, 0);
            end
            frame++;
        end
        bpos = (bpos + 1) % 256;
    endtask

    task automatic run_steps(input int n, input int skip_at);
        for (int i = 0; i < n; i++) step(bpos == skip_at);
    endtask

    task automatic map_write(input int ts, input int code);
        cfg_we = 1'b1; cfg_ts = 5'(ts); cfg_code = 2'(code);
        @(negedge clk);
        cfg_we = 1'b0;
        bmap_sh[ts] = code;
    endtask

    task automatic map_load();
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        pend = 1;
        check(load_pending == 1'b1, "R3", "load_pending after strobe", load_pending, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) begin bmap_act[i] = 3; bmap_sh[i] = 3; end
        rst = 1'b1; loop_bit_en = '0; loop_oh = '0; loop_data = '0;
        e1_en = 0; nom_en = 0; ais_ctl = '0; cfg_we = 0; cfg_load = 0;
        cfg_ts = '0; cfg_code = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R5 reset state
        check(e1_data == 0, "R5", "reset e1_data", e1_data, 0);
        check(e1_fp == 0, "R5", "reset e1_fp", e1_fp, 0);
        check(gap_tick == 0, "R5", "reset gap_tick", gap_tick, 0);
        check(fifo_err == 0, "R5", "reset fifo_err", fifo_err, 0);
        check(load_pending == 0, "R5", "reset load_pending", load_pending, 0);

        // map A staged, frame 0 still idle (R2, R3)
        for (int t = 0; t < 32; t++) map_write(t, t % 4);
        map_load();
        run_steps(256, -1);
        // frame 1 on map A, map B staged mid-frame (R3)
        run_steps(100, -1);
        for (int t = 0; t < 32; t++) map_write(t, (t + 1) % 4);
        map_load();
        run_steps(156, -1);
        // frame 2: loop 1 muted (R6)
        bais = 4'b0010; ais_ctl = bais;
        run_steps(256, -1);
        // frame 3: underflow at position 64 on loop 1 (R8)
        bais = '0; ais_ctl = bais;
        run_steps(65, 64);
        check(fifo_err == 3'b010, "R8", "fifo_err after underflow", fifo_err, 2);
        run_steps(191, -1);
        // frame 4: normal output resumes (R8)
        run_steps(256, -1);
        // frame 5: full-stream AIS on nominal strobe (R7)
        bais = 4'b1000; ais_ctl = bais;
        run_steps(256, -1);
        check(fifo_err == 3'b010, "R7", "no FIFO reads under full AIS", fifo_err, 2);
        bais = '0; ais_ctl = bais;
        // frame 6 normal
        run_steps(256, -1);
        // overflow on loop 2 (R9)
        for (int i = 0; i < 17; i++) push_bit(2, 1'b0, 1'b0);
        check(fifo_err == 3'b110, "R9", "fifo_err after overflow", fifo_err, 6);
        bhold = 1; hold_req = "R9";
        run_steps(12, -1);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R5", "pending expected bits", exp_q.size(), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule